// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Unit

This block multiplies a stream of signed 8-bit row vectors by a square matrix of signed 8-bit weights. The matrix is stored in an N x N grid of multiply-accumulate cells. Weights are first shifted into the grid one row per cycle through a dedicated load port. They then stay in place while input rows stream in, one per cycle. Element k of each input row is delayed by k cycles before it enters grid row k. It then moves rightwards from cell to cell. Partial sums move downwards through each column and collect one product per cell.

The column sums leave the grid staggered in time. Per-column delay lines realign them into a single result row. That row is written into a small bank of 32-bit accumulators, addressed per input row. A mode bit on each input row decides whether the result replaces the stored entry or is added to it. This lets results be built up over several passes, for example when a long dot product is split across several weight loads. A batch of B input rows yields B result rows on B consecutive cycles, following a fixed fill latency.

The grid is not drained or protected when new weights arrive. A weight load should therefore begin only after all earlier input rows have produced their results.

Top module: `sa_matrix_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `busy` are 0. Every accumulator entry holds zero, so the first accumulate-mode write to an entry returns the plain product.
- R2: Each cycle with `wt_valid` high shifts `wt_row` into the grid. After N such cycles, weight row k (the multiplier of input element k) is the row that was presented at load step N-1-k. In other words, the last row loaded becomes row 0.
- R3: `busy` is 1 while a load has taken between 1 and N-1 rows, and 0 otherwise. An input row offered while `busy` is high, or in the same cycle as `wt_valid`, is dropped: it produces no output and leaves the accumulators unchanged.
- R4: An input row accepted at a clock edge produces its result at the output 2N edges later, counting that edge as the first. Output element j equals the sum over k of x[k]*W[k][j]. Input element k sits in `in_vec[8k+7:8k]`, weight column j sits in `wt_row[8j+7:8j]`, and output column j sits in `out_row[32j+31:32j]`.
- R5: Input rows accepted on consecutive cycles produce `out_valid` on exactly that many consecutive cycles, in the same order.
- R6: Products are signed 8x8. Sums are formed at 32 bits, so a full row of -128 x -128 gives +65536 per column without wrapping.
- R7: `in_mode`=0 makes the result overwrite the addressed accumulator entry. `in_mode`=1 adds the result to the stored entry. The output shows the new entry value in both cases.
- R8: A write to one accumulator address leaves every other address unchanged.
- R9: `out_addr` gives the `in_addr` of the input row whose result is being shown.
- R10: Idle cycles between accepted input rows appear as the same idle gaps in `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_valid | input | 1 | Shift one weight row into the grid |
| wt_row | input | N*8 | Weight row, column j at bits 8j+7:8j |
| busy | output | 1 | Weight load in progress; inputs are dropped |
| in_valid | input | 1 | Input row offered this cycle |
| in_mode | input | 1 | 0 overwrite, 1 accumulate |
| in_addr | input | ADDR_W | Accumulator entry for this row |
| in_vec | input | N*8 | Input row, element k at bits 8k+7:8k |
| out_valid | output | 1 | Result row valid |
| out_addr | output | ADDR_W | Accumulator entry of the result |
| out_row | output | N*32 | New accumulator contents, column j at bits 32j+31:32j |

## Verification
A stuck or misordered weight register corrupts the columns of every later result, starting with the first row accepted after the load, 2N cycles later. A skew or deskew stage of the wrong length mixes elements from neighbouring rows. With distinct back-to-back rows this yields wrong sums, even though valid timing looks correct. A fault in the valid/address tag pipeline shifts `out_valid` away from the 2N-cycle slot or swaps `out_addr`, which is visible on the first output. A faulty accumulator read or mode decode stays hidden until the second write to the same entry. The bench therefore repeats addresses and alternates the two modes.

// File: rtl/sa_pkg.sv
// Package sa_pkg
// Shared constants and the accumulate-mode encoding used by the systolic
// matrix unit. Assumes signed two's-complement operands throughout.
package sa_pkg;

    localparam int unsigned DEF_N     = 4;
    localparam int unsigned DEF_DW    = 8;
    localparam int unsigned DEF_AW    = 32;
    localparam int unsigned DEF_DEPTH = 8;

    typedef enum logic {
        MODE_OVERWRITE = 1'b0,
        MODE_ACCUM     = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/sa_delay.sv
// Module sa_delay
// Fixed-length register delay line used to skew inputs and realign column
// sums. Assumes D >= 1; zero-length paths are wired directly by the caller.
module sa_delay #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [D];

    // Shift the value one stage per clock, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < D; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[D-1];

endmodule

// File: rtl/sa_mac_cell.sv
// Module sa_mac_cell
// One grid cell: holds a resident weight (supplied from outside), registers
// the passing input element and adds its signed product to the partial sum
// coming from above. Assumes AW > 2*DW.
module sa_mac_cell #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] w,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [AW-1:0] ps_in,
    output logic signed [DW-1:0] x_out,
    output logic signed [AW-1:0] ps_out
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    assign prod     = x_in * w;
    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

    // Pass the input element right and the updated partial sum down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_out  <= '0;
            ps_out <= '0;
        end else begin
            x_out  <= x_in;
            ps_out <= ps_in + prod_ext;
        end
    end

endmodule

// File: rtl/sa_acc_bank.sv
// Module sa_acc_bank
// Addressed bank of N-wide accumulator rows. On each tagged result it either
// replaces or adds to the addressed row and presents the new value.
// Assumes DEPTH <= 2**ADDR_W and addresses stay below DEPTH.
module sa_acc_bank
    import sa_pkg::*;
#(
    parameter int N      = 4,
    parameter int AW     = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_valid,
    input  logic              tag_mode,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [N*AW-1:0]   sum_vec,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [N*AW-1:0]   out_row
);

    logic [N*AW-1:0] mem [DEPTH];
    logic [N*AW-1:0] nxt;
    logic [N*AW-1:0] base;

    // Select the stored row or zero, then add the new column sums.
    always_comb begin
        base = (tag_mode == MODE_ACCUM) ? mem[tag_addr] : '0;
        for (int j = 0; j < N; j++)
            nxt[j*AW +: AW] = base[j*AW +: AW] + sum_vec[j*AW +: AW];
    end

    // Commit the new row and drive the registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_row   <= '0;
        end else begin
            out_valid <= tag_valid;
            if (tag_valid) begin
                mem[tag_addr] <= nxt;
                out_row       <= nxt;
                out_addr      <= tag_addr;
            end
        end
    end

endmodule

// File: rtl/sa_matrix_unit.sv
// Module sa_matrix_unit
// Weight-stationary N x N systolic matrix unit. Weights shift in one row per
// cycle; input rows are skewed into the grid, column sums are realigned and
// committed into an addressed accumulator bank 2N cycles after acceptance.
// Assumes no weight load starts while accepted rows are still in flight.
module sa_matrix_unit
    import sa_pkg::*;
#(
    parameter int N      = DEF_N,
    parameter int DW     = DEF_DW,
    parameter int AW     = DEF_AW,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_valid,
    input  logic [N*DW-1:0]   wt_row,
    output logic              busy,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [N*DW-1:0]   in_vec,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [N*AW-1:0]   out_row
);

    localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
    localparam int TAG_W = 2 + ADDR_W;
    localparam int TAG_D = 2 * N - 1;

    logic [N*DW-1:0]        wrow_q [N];
    logic [CNT_W-1:0]       load_cnt;
    logic                   accept;
    logic signed [DW-1:0]   x_h  [N][N+1];
    logic signed [AW-1:0]   ps_v [N+1][N];
    logic [N*AW-1:0]        y_vec;
    logic [TAG_W-1:0]       tag_in, tag_out;

    // Shift weight rows down the grid and count load steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) wrow_q[k] <= '0;
            load_cnt <= '0;
        end else if (wt_valid) begin
            wrow_q[0] <= wt_row;
            for (int k = 1; k < N; k++) wrow_q[k] <= wrow_q[k-1];
            load_cnt <= (load_cnt == CNT_W'(N-1)) ? '0 : load_cnt + 1'b1;
        end
    end

    assign busy   = (load_cnt != '0);
    assign accept = in_valid & ~busy & ~wt_valid;

    genvar k, j;
    generate
        for (k = 0; k < N; k++) begin : g_row
            logic [DW-1:0] elem;
            assign elem = accept ? in_vec[k*DW +: DW] : '0;
            if (k == 0) begin : g_noskew
                assign x_h[k][0] = elem;
            end else begin : g_skew
                logic [DW-1:0] skewed;
                sa_delay #(.W(DW), .D(k)) u_skew (
                    .clk(clk), .rst_n(rst_n), .d(elem), .q(skewed));
                assign x_h[k][0] = skewed;
            end
            for (j = 0; j < N; j++) begin : g_col
                sa_mac_cell #(.DW(DW), .AW(AW)) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .w     (wrow_q[k][j*DW +: DW]),
                    .x_in  (x_h[k][j]),
                    .ps_in (ps_v[k][j]),
                    .x_out (x_h[k][j+1]),
                    .ps_out(ps_v[k+1][j])
                );
            end
        end

        for (j = 0; j < N; j++) begin : g_out
            assign ps_v[0][j] = '0;
            if (j == N - 1) begin : g_nodeskew
                assign y_vec[j*AW +: AW] = ps_v[N][j];
            end else begin : g_deskew
                sa_delay #(.W(AW), .D(N - 1 - j)) u_deskew (
                    .clk(clk), .rst_n(rst_n),
                    .d(ps_v[N][j]), .q(y_vec[j*AW +: AW]));
            end
        end
    endgenerate

    assign tag_in = {accept, in_mode, in_addr};

    sa_delay #(.W(TAG_W), .D(TAG_D)) u_tag (
        .clk(clk), .rst_n(rst_n), .d(tag_in), .q(tag_out));

    sa_acc_bank #(.N(N), .AW(AW), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_valid(tag_out[TAG_W-1]),
        .tag_mode (tag_out[TAG_W-2]),
        .tag_addr (tag_out[ADDR_W-1:0]),
        .sum_vec  (y_vec),
        .out_valid(out_valid),
        .out_addr (out_addr),
        .out_row  (out_row)
    );

endmodule

// File: rtl/sa_matrix_unit_chk.sv
// Module sa_matrix_unit_chk
// Port-level checker for sa_matrix_unit: keeps its own history of accepted
// rows and load steps and compares them with the outputs.
module sa_matrix_unit_chk #(
    parameter int N      = 4,
    parameter int AW     = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wt_valid,
    input logic              busy,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [N*AW-1:0]   out_row
);

    localparam int LAT = 2 * N;

    logic [LAT-1:0]    hist_v;
    logic [ADDR_W-1:0] hist_a [LAT];
    int                ld_seen;
    logic              acc_ok;

    assign acc_ok = in_valid && !busy && !wt_valid;

    // Track accepted rows, their addresses and the load step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_v  <= '0;
            for (int i = 0; i < LAT; i++) hist_a[i] <= '0;
            ld_seen <= 0;
        end else begin
            hist_v    <= {hist_v[LAT-2:0], acc_ok};
            hist_a[0] <= in_addr;
            for (int i = 1; i < LAT; i++) hist_a[i] <= hist_a[i-1];
            if (wt_valid) ld_seen <= (ld_seen == N - 1) ? 0 : ld_seen + 1;
        end
    end

    // R4 / R5 / R10: a result appears exactly 2N edges after its acceptance.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist_v[LAT-1]);

    // R9: the result carries the address of its own input row.
    p_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr == hist_a[LAT-1]);

    // R3: busy follows the count of partial load steps.
    p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (ld_seen != 0));

    // R2: the final load step of a sequence releases busy on the next cycle.
    p_load_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_valid && ld_seen == N - 1) |=> !busy);

    // R6: every presented result is fully defined.
    p_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_row));

endmodule

bind sa_matrix_unit sa_matrix_unit_chk #(.N(N), .AW(AW), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sa_matrix_unit_test.sv
// Directed bench for sa_matrix_unit: one task per scenario, a negedge
// monitor compares each result against a bench-side reference model.
module sa_matrix_unit_test;

    localparam int N = 4, DW = 8, AW = 32, DEPTH = 8, AD = 3;
    localparam int LAT = 2 * N;

    typedef int vec_t [N];
    typedef int mat_t [N][N];

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wt_valid = 1'b0;
    logic [N*DW-1:0]   wt_row = '0;
    logic              busy;
    logic              in_valid = 1'b0;
    logic              in_mode = 1'b0;
    logic [AD-1:0]     in_addr = '0;
    logic [N*DW-1:0]   in_vec = '0;
    logic              out_valid;
    logic [AD-1:0]     out_addr;
    logic [N*AW-1:0]   out_row;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    mat_t wcur;
    int   acc_m [DEPTH][N];
    logic [N*AW-1:0] e_row [64];
    int   e_addr [64];
    int   e_cyc  [64];
    string e_req [64];
    int   e_n = 0, c_n = 0;

    sa_matrix_unit uut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what,
                         logic [N*AW-1:0] act, logic [N*AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare each presented result against the next expected entry.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (c_n >= e_n) begin
                check(0, "R3/R10", "unexpected output row", out_row, '0);
            end else begin
                check(out_row == e_row[c_n], e_req[c_n], "result row", out_row, e_row[c_n]);
                check(out_addr == AD'(e_addr[c_n]), "R9", "result address",
                      (N*AW)'(out_addr), (N*AW)'(e_addr[c_n]));
                check(cyc == e_cyc[c_n], "R4", "result cycle",
                      (N*AW)'(cyc), (N*AW)'(e_cyc[c_n]));
                c_n++;
            end
        end
    end

    function automatic logic [N*DW-1:0] pack(vec_t v);
        logic [N*DW-1:0] r;
        for (int k = 0; k < N; k++) r[k*DW +: DW] = v[k][DW-1:0];
        return r;
    endfunction

    task automatic load_weights(mat_t m, string req);
        for (int i = 0; i < N; i++) begin
            wt_valid = 1'b1;
            wt_row   = pack(m[N-1-i]);
            @(negedge clk);
            check(busy == (i + 1 < N), req, "busy during load",
                  (N*AW)'(busy), (N*AW)'(i + 1 < N));
        end
        wt_valid = 1'b0;
        wcur = m;
    endtask

    task automatic send_row(vec_t x, bit mode, int addr, string req);
        logic [N*AW-1:0] ev;
        for (int j = 0; j < N; j++) begin
            int s = 0;
            for (int k = 0; k < N; k++) s += x[k] * wcur[k][j];
            acc_m[addr][j] = (mode ? acc_m[addr][j] : 0) + s;
            ev[j*AW +: AW] = acc_m[addr][j];
        end
        e_row[e_n] = ev; e_addr[e_n] = addr; e_cyc[e_n] = cyc + LAT; e_req[e_n] = req;
        e_n++;
        in_valid = 1'b1; in_mode = mode; in_addr = AD'(addr); in_vec = pack(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(string req);
        repeat (LAT + 3) @(negedge clk);
        check(c_n == e_n, req, "result count", (N*AW)'(c_n), (N*AW)'(e_n));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", (N*AW)'(out_valid), '0);
        check(busy == 1'b0, "R1", "busy after reset", (N*AW)'(busy), '0);
    endtask

    task automatic t_single();
        mat_t w;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) w[k][j] = 3 * k - 5 * j + 1 + k * j;
        load_weights(w, "R2");
        send_row('{1, 2, 3, 4}, 1'b0, 0, "R4");
        send_row('{-7, 5, 0, 9}, 1'b1, 5, "R1");
        drain("R4");
    endtask

    task automatic t_batch();
        for (int b = 0; b < 6; b++)
            send_row('{b + 1, -2 * b, 3 - b, b * b}, 1'b0, b, "R5");
        drain("R5");
    endtask

    task automatic t_gap();
        send_row('{10, -10, 20, -20}, 1'b0, 6, "R10");
        repeat (2) @(negedge clk);
        send_row('{-3, 4, -5, 6}, 1'b0, 7, "R10");
        @(negedge clk);
        send_row('{1, 1, 1, 1}, 1'b0, 6, "R10");
        drain("R10");
    endtask

    task automatic t_accum();
        send_row('{2, 0, -1, 3}, 1'b0, 2, "R7");
        send_row('{1, 1, 1, 1}, 1'b1, 2, "R7");
        send_row('{4, 4, 0, -4}, 1'b1, 2, "R7");
        send_row('{-9, 8, 7, -6}, 1'b0, 3, "R8");
        send_row('{5, -5, 5, -5}, 1'b0, 2, "R7");
        drain("R7");
        send_row('{0, 0, 0, 0}, 1'b1, 3, "R8");
        drain("R8");
    endtask

    task automatic t_signed();
        mat_t w;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) w[k][j] = (j == 1) ? 127 : -128;
        load_weights(w, "R2");
        send_row('{-128, -128, -128, -128}, 1'b0, 0, "R6");
        send_row('{127, 127, 127, 127}, 1'b0, 1, "R6");
        send_row('{-128, 127, -128, 127}, 1'b1, 0, "R6");
        drain("R6");
    endtask

    task automatic t_busy();
        mat_t w;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) w[k][j] = (k + 1) * (j + 2) - 7;
        // Input offered together with the first load step is dropped.
        wt_valid = 1'b1; wt_row = pack(w[N-1]);
        in_valid = 1'b1; in_mode = 1'b0; in_addr = AD'(4); in_vec = pack('{50, 50, 50, 50});
        @(negedge clk);
        wt_valid = 1'b0;
        check(busy == 1'b1, "R3", "busy after one load step", (N*AW)'(busy), 1);
        // Input offered while busy is dropped.
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        check(c_n == e_n, "R3", "dropped rows produce nothing", (N*AW)'(c_n), (N*AW)'(e_n));
        for (int i = 1; i < N; i++) begin
            wt_valid = 1'b1; wt_row = pack(w[N-1-i]);
            @(negedge clk);
        end
        wt_valid = 1'b0;
        wcur = w;
        check(busy == 1'b0, "R3", "busy after full load", (N*AW)'(busy), 0);
        send_row('{1, -1, 2, -2}, 1'b1, 4, "R3");
        drain("R3");
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++)
            for (int j = 0; j < N; j++) acc_m[a][j] = 0;
        t_reset();
        t_single();
        t_batch();
        t_gap();
        t_accum();
        t_signed();
        t_busy();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule